// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Codec

This block converts between NRZ data and the two rails of a bipolar (AMI) line, one bit per clock enable. It supports both zero-substitution schemes used on coaxial telecom lines. The three-zero scheme (B3ZS) serves the T3 and STS-1 rates, and the four-zero scheme (HDB3) serves E3. On transmit, it replaces every run of zeros of the scheme's length with a substitution codeword that holds a deliberate bipolar violation. On receive, it recognises those codewords, removes them, and strobes a violation flag for anything that breaks the code.

When coding is switched off, both sides carry the rails through unchanged. Transmit takes the positive rail on `txData` and the negative rail on `txNegIn`. Receive returns the rails on `rxData` and `rxAux`. When coding is on, `txData` is the NRZ input, `rxData` is the NRZ output and `rxAux` is the violation strobe.

The transmit window and the receive window both have a depth equal to the run length, which is 3 or 4. Latency in steps is therefore fixed for a given mode.

Top module: `zs_codec`

## Requirements
- R1: `lineMode` selects the scheme: code 0 selects HDB3 with a run length of 4, and codes 1 and 2 (and 3) select B3ZS with a run length of 3.
- R2: In B3ZS, each run of 3 input zeros is sent as 0,0,V if the count of pulses sent since the last V is odd, and as B,0,V if it is even.
- R3: In HDB3, each run of 4 input zeros is sent as 0,0,0,V after an odd count and as B,0,0,V after an even count.
- R4: Ones and B pulses alternate polarity, and a V pulse repeats the polarity of the previous pulse. The first pulse after reset is positive, and `txPos` and `txNeg` are never both high in coded mode.
- R5: With coding on, the rail pair for input bit k appears after step k+N, where N is the run length. `txNegIn` has no effect.
- R6: With `codeEn` low, each step registers `txData`/`txNegIn` onto `txPos`/`txNeg` and `rxPos`/`rxNeg` onto `rxData`/`rxAux`, with a latency of one step.
- R7: With coding on, the decoder removes the B and V pulses of valid codewords. After step k+N, `rxData` shows the mark (either rail) of received symbol k.
- R8: With coding on, a pulse whose polarity equals the previous pulse and which does not complete a valid codeword raises `rxAux` for that symbol.
- R9: With coding on, `rxAux` rises for the received zero that completes a run of N zeros, and only once per run. After reset, zeros are not flagged until the first pulse arrives.
- R10: While `bitEn` is low, no state or output changes.
- R11: Synchronous active-high `rst` clears all outputs and the polarity, parity and window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | One bit step per high cycle |
| lineMode | input | 2 | 0 = E3/HDB3, 1 = T3/B3ZS, 2 = STS-1/B3ZS |
| codeEn | input | 1 | 1 = code/decode, 0 = rail pass-through |
| txData | input | 1 | NRZ data (coded) or positive rail (bypass) |
| txNegIn | input | 1 | Negative rail in bypass; ignored when coding |
| txPos | output | 1 | Positive line pulse |
| txNeg | output | 1 | Negative line pulse |
| rxPos | input | 1 | Received positive pulse |
| rxNeg | input | 1 | Received negative pulse |
| rxData | output | 1 | Decoded NRZ (coded) or positive rail (bypass) |
| rxAux | output | 1 | Violation strobe (coded) or negative rail (bypass) |

## Verification
The properties assume that `lineMode` and `codeEn` change only while reset is held. They also assume that the received rails are never both high in one symbol. The stimulus sets both controls once per run, under reset, and drives the receiver only with single-rail symbols. Those symbols come either from the block's own transmit output looped back or from hand-built rail strings. Bit steps are mixed with idle cycles at random, so the hold behaviour is exercised between steps.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam logic [1:0] MODE_E3   = 2'd0;
  localparam logic [1:0] MODE_T3   = 2'd1;
  localparam logic [1:0] MODE_STS1 = 2'd2;

  // kind of symbol waiting in the transmit window
  typedef enum logic [2:0] {
    SYM_FILL,   // nothing yet (after reset), never part of a zero run
    SYM_ZERO,
    SYM_ONE,
    SYM_BIP,    // substitution pulse that obeys alternation
    SYM_VIO     // substitution pulse that violates alternation
  } symKind_e;

  typedef struct packed {
    logic step;
    logic hdb3;
    logic coding;
  } zsStrobe_t;
endpackage

// File: rtl/zs_ctrl.sv
module zs_ctrl
  import zs_pkg::*;
(
  input  logic       bitEn,
  input  logic [1:0] lineMode,
  input  logic       codeEn,
  output zsStrobe_t  stb
);
  always_comb begin
    stb.step   = bitEn;
    stb.hdb3   = (lineMode == MODE_E3);
    stb.coding = codeEn;
  end
endmodule

// File: rtl/zs_encoder.sv
module zs_encoder
  import zs_pkg::*;
#(
  parameter int RUN_B3ZS = 3,
  parameter int RUN_HDB3 = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  zsStrobe_t stb,
  input  logic      txData,
  input  logic      txNegIn,
  output logic      txPos,
  output logic      txNeg
);
  localparam int WIN = (RUN_HDB3 > RUN_B3ZS) ? RUN_HDB3 : RUN_B3ZS;
  localparam int DW  = $clog2(WIN + 1);

  symKind_e   win    [WIN];
  symKind_e   nxtWin [WIN];
  symKind_e   outSym;
  logic       lastNeg;
  logic       oddMarks;
  logic       runZero;
  logic       effOdd;
  logic       outPulse;
  logic       outNeg;
  logic [DW-1:0] lastIdx;

  assign lastIdx = (stb.hdb3 ? DW'(RUN_HDB3) : DW'(RUN_B3ZS)) - DW'(1);

  always_comb begin
    outSym  = SYM_FILL;
    runZero = ~txData;
    for (int i = 0; i < WIN; i++) begin
      if (DW'(i) == lastIdx) outSym = win[i];
      if (DW'(i) < lastIdx && win[i] != SYM_ZERO) runZero = 1'b0;
    end

    case (outSym)
      SYM_ONE: effOdd = ~oddMarks;
      SYM_VIO: effOdd = 1'b0;
      default: effOdd = oddMarks;
    endcase

    nxtWin[0] = txData ? SYM_ONE : SYM_ZERO;
    for (int i = 1; i < WIN; i++) nxtWin[i] = win[i-1];
    if (runZero) begin
      nxtWin[0] = SYM_VIO;
      for (int i = 1; i < WIN; i++)
        if (DW'(i) == lastIdx) nxtWin[i] = effOdd ? SYM_ZERO : SYM_BIP;
    end

    outPulse = (outSym == SYM_ONE) || (outSym == SYM_BIP) || (outSym == SYM_VIO);
    outNeg   = (outSym == SYM_VIO) ? lastNeg : ~lastNeg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN; i++) win[i] <= SYM_FILL;
      lastNeg  <= 1'b1;
      oddMarks <= 1'b0;
      txPos    <= 1'b0;
      txNeg    <= 1'b0;
    end else if (stb.step) begin
      if (stb.coding) begin
        for (int i = 0; i < WIN; i++) win[i] <= nxtWin[i];
        txPos <= outPulse & ~outNeg;
        txNeg <= outPulse & outNeg;
        if (outPulse) lastNeg <= outNeg;
        if (outSym == SYM_VIO) oddMarks <= 1'b0;
        else if (outPulse)     oddMarks <= ~oddMarks;
      end else begin
        txPos <= txData;
        txNeg <= txNegIn;
      end
    end
  end
endmodule

// File: rtl/zs_decoder.sv
module zs_decoder
  import zs_pkg::*;
#(
  parameter int RUN_B3ZS = 3,
  parameter int RUN_HDB3 = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  zsStrobe_t stb,
  input  logic      rxPos,
  input  logic      rxNeg,
  output logic      rxData,
  output logic      rxAux
);
  localparam int WIN = (RUN_HDB3 > RUN_B3ZS) ? RUN_HDB3 : RUN_B3ZS;
  localparam int DW  = $clog2(WIN + 1);

  logic [WIN-1:0] rawMk, decMk, violMk;
  logic [WIN-1:0] nxtDec;
  logic [DW-1:0]  zeroCnt, lastIdx, runLen;
  logic lastNeg, hasPrev;
  logic inMark, inNeg, isViol, zForm, bForm, subOk, excess;
  logic decOut, violOut;

  assign runLen  = stb.hdb3 ? DW'(RUN_HDB3) : DW'(RUN_B3ZS);
  assign lastIdx = runLen - DW'(1);

  always_comb begin
    inMark = rxPos | rxNeg;
    inNeg  = rxNeg & ~rxPos;
    isViol = inMark & hasPrev & (inNeg == lastNeg);
    if (stb.hdb3) begin
      zForm = ~rawMk[0] & ~rawMk[1] & ~rawMk[2];
      bForm = ~rawMk[0] & ~rawMk[1] &  rawMk[2];
    end else begin
      zForm = ~rawMk[0] & ~rawMk[1];
      bForm = ~rawMk[0] &  rawMk[1];
    end
    subOk  = isViol & (zForm | bForm);
    excess = ~inMark & (zeroCnt == lastIdx);

    nxtDec  = {decMk[WIN-2:0], inMark & ~subOk};
    decOut  = 1'b0;
    violOut = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      if (DW'(i) == lastIdx) begin
        decOut  = decMk[i];
        violOut = violMk[i];
        if (subOk && bForm) nxtDec[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawMk   <= '0;
      decMk   <= '0;
      violMk  <= '0;
      zeroCnt <= DW'(WIN);
      lastNeg <= 1'b1;
      hasPrev <= 1'b0;
      rxData  <= 1'b0;
      rxAux   <= 1'b0;
    end else if (stb.step) begin
      if (stb.coding) begin
        rawMk  <= {rawMk[WIN-2:0], inMark};
        decMk  <= nxtDec;
        violMk <= {violMk[WIN-2:0], (isViol & ~subOk) | excess};
        if (inMark)                 zeroCnt <= '0;
        else if (zeroCnt < runLen)  zeroCnt <= zeroCnt + DW'(1);
        if (inMark) begin
          lastNeg <= inNeg;
          hasPrev <= 1'b1;
        end
        rxData <= decOut;
        rxAux  <= violOut;
      end else begin
        rxData <= rxPos;
        rxAux  <= rxNeg;
      end
    end
  end
endmodule

// File: rtl/zs_codec.sv
module zs_codec
  import zs_pkg::*;
#(
  parameter int RUN_B3ZS = 3,
  parameter int RUN_HDB3 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitEn,
  input  logic [1:0] lineMode,
  input  logic       codeEn,
  input  logic       txData,
  input  logic       txNegIn,
  output logic       txPos,
  output logic       txNeg,
  input  logic       rxPos,
  input  logic       rxNeg,
  output logic       rxData,
  output logic       rxAux
);
  zsStrobe_t stb;

  zs_ctrl u_ctrl (
    .bitEn(bitEn), .lineMode(lineMode), .codeEn(codeEn), .stb(stb)
  );

  zs_encoder #(.RUN_B3ZS(RUN_B3ZS), .RUN_HDB3(RUN_HDB3)) u_enc (
    .clk(clk), .rst(rst), .stb(stb), .txData(txData), .txNegIn(txNegIn),
    .txPos(txPos), .txNeg(txNeg)
  );

  zs_decoder #(.RUN_B3ZS(RUN_B3ZS), .RUN_HDB3(RUN_HDB3)) u_dec (
    .clk(clk), .rst(rst), .stb(stb), .rxPos(rxPos), .rxNeg(rxNeg),
    .rxData(rxData), .rxAux(rxAux)
  );
endmodule

// File: rtl/zs_codec_chk.sv
module zs_codec_chk (
  input logic       clk,
  input logic       rst,
  input logic       bitEn,
  input logic [1:0] lineMode,
  input logic       codeEn,
  input logic       txData,
  input logic       txNegIn,
  input logic       txPos,
  input logic       txNeg,
  input logic       rxPos,
  input logic       rxNeg,
  input logic       rxData,
  input logic       rxAux
);
  logic unusedMode;
  assign unusedMode = ^lineMode;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> $stable({txPos, txNeg, rxData, rxAux})); // R10

  AST_SINGLE_RAIL: assert property (@(posedge clk) disable iff (rst)
    (codeEn && bitEn) |=> !(txPos && txNeg)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!txPos && !txNeg && !rxData && !rxAux)); // R11

  AST_BYPASS_TX: assert property (@(posedge clk) disable iff (rst)
    (!codeEn && bitEn) |=> (txPos == $past(txData) && txNeg == $past(txNegIn))); // R6

  AST_BYPASS_RX: assert property (@(posedge clk) disable iff (rst)
    (!codeEn && bitEn) |=> (rxData == $past(rxPos) && rxAux == $past(rxNeg))); // R6
endmodule

bind zs_codec zs_codec_chk u_chk (
  .clk(clk), .rst(rst), .bitEn(bitEn), .lineMode(lineMode), .codeEn(codeEn),
  .txData(txData), .txNegIn(txNegIn), .txPos(txPos), .txNeg(txNeg),
  .rxPos(rxPos), .rxNeg(rxNeg), .rxData(rxData), .rxAux(rxAux)
);

// File: tb/zs_codec_test.sv
module zs_codec_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, bitEn, codeEn, txData, txNegIn, rxPos, rxNeg;
  logic [1:0] lineMode;
  logic txPos, txNeg, rxData, rxAux;

  int nVec = 0;
  int nBad = 0;
  localparam int MAXL = 600;
  bit inBit [MAXL];
  bit ePos  [MAXL];
  bit eNeg  [MAXL];

  zs_codec uut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .lineMode(lineMode), .codeEn(codeEn),
    .txData(txData), .txNegIn(txNegIn), .txPos(txPos), .txNeg(txNeg),
    .rxPos(rxPos), .rxNeg(rxNeg), .rxData(rxData), .rxAux(rxAux)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; bitEn = 1'b0; txData = 1'b0; txNegIn = 1'b0; rxPos = 1'b0; rxNeg = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R11", "outputs after reset", {txPos, txNeg, rxData, rxAux}, 0);
  endtask

  // expected line rails for inBit[0..n-1]: greedy scan of zero runs
  task automatic encModel(input int n, input int runLen);
    bit lastNeg = 1'b1;
    bit odd = 1'b0;
    int i = 0;
    while (i < n) begin
      bit allZ = (i + runLen <= n);
      for (int k = 0; k < runLen && allZ; k++) if (inBit[i+k]) allZ = 1'b0;
      if (allZ) begin
        for (int k = 0; k < runLen; k++) begin ePos[i+k] = 0; eNeg[i+k] = 0; end
        if (!odd) begin
          lastNeg = ~lastNeg;
          ePos[i] = ~lastNeg; eNeg[i] = lastNeg;
        end
        ePos[i+runLen-1] = ~lastNeg; eNeg[i+runLen-1] = lastNeg;
        odd = 1'b0;
        i += runLen;
      end else begin
        if (inBit[i]) begin
          lastNeg = ~lastNeg;
          ePos[i] = ~lastNeg; eNeg[i] = lastNeg;
          odd = ~odd;
        end else begin
          ePos[i] = 0; eNeg[i] = 0;
        end
        i++;
      end
    end
  endtask

  task automatic runCoded(input logic [1:0] mode, input int n, input string req);
    int runLen = (mode == 2'd0) ? 4 : 3;
    int j = 0;
    lineMode = mode; codeEn = 1'b1;
    doReset();
    for (int s = 0; s < n; s++) inBit[s] = ($urandom % 3) == 0;
    encModel(n, runLen);
    while (j < n) begin
      logic en;
      logic [3:0] prevOut;
      en = ($urandom % 4) != 0;
      prevOut = {txPos, txNeg, rxData, rxAux};
      txData = inBit[j]; txNegIn = $urandom; bitEn = en;
      @(posedge clk); @(negedge clk);
      bitEn = 1'b0;
      if (en) begin
        int k;
        // R5: rails of bit j-runLen; R4 polarity, R1 run length per mode
        chk(req, "R4,R5 txPos", txPos, (j >= runLen) ? ePos[j-runLen] : 0);
        chk(req, "R4,R5 txNeg", txNeg, (j >= runLen) ? eNeg[j-runLen] : 0);
        k = j - 1 - 2 * runLen;
        chk("R7", "loopback rxData", rxData, (k >= 0) ? inBit[k] : 0);
        chk("R8", "loopback rxAux clean", rxAux, 0);
        rxPos = txPos; rxNeg = txNeg;
        j++;
      end else begin
        chk("R10", "idle hold", {txPos, txNeg, rxData, rxAux}, prevOut);
      end
    end
  endtask

  task automatic runBypass(input int n);
    int j = 0;
    lineMode = 2'd1; codeEn = 1'b0;
    doReset();
    while (j < n) begin
      logic en;
      logic [3:0] prevOut;
      logic a, b, c, d;
      en = ($urandom % 4) != 0;
      prevOut = {txPos, txNeg, rxData, rxAux};
      a = $urandom; b = $urandom; c = $urandom; d = $urandom;
      txData = a; txNegIn = b; rxPos = c; rxNeg = d; bitEn = en;
      @(posedge clk); @(negedge clk);
      bitEn = 1'b0;
      if (en) begin
        chk("R6", "bypass tx rails", {txPos, txNeg}, {a, b});
        chk("R6", "bypass rx rails", {rxData, rxAux}, {c, d});
        j++;
      end else begin
        chk("R10", "idle hold bypass", {txPos, txNeg, rxData, rxAux}, prevOut);
      end
    end
  endtask

  // rails: P = positive, N = negative, 0 = none
  task automatic decDirected(input logic [1:0] mode, input string rails,
                             input string dExp, input string aExp, input string req);
    int runLen = (mode == 2'd0) ? 4 : 3;
    int n = rails.len();
    lineMode = mode; codeEn = 1'b1;
    doReset();
    for (int j = 0; j < n + runLen; j++) begin
      byte c = (j < n) ? rails[j] : "0";
      rxPos = (c == "P"); rxNeg = (c == "N"); txData = 1'b0; bitEn = 1'b1;
      @(posedge clk); @(negedge clk);
      bitEn = 1'b0;
      if (j >= runLen && j - runLen < n) begin
        int k = j - runLen;
        chk(req, $sformatf("R7 rxData sym %0d", k), rxData, dExp[k] == "1");
        chk(req, $sformatf("rxAux sym %0d", k), rxAux, aExp[k] == "1");
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog R10: got 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    lineMode = 2'd1; codeEn = 1'b1;
    @(negedge clk);
    runCoded(2'd1, 400, "R2");            // T3 B3ZS
    runCoded(2'd2, 300, "R1,R2");         // STS-1 also B3ZS
    runCoded(2'd0, 400, "R1,R3");         // E3 HDB3
    runBypass(80);
    // B3ZS: stray V, excess zeros, valid B0V
    decDirected(2'd1, "PNN000PN0NP", "11100010001", "00100100000", "R8,R9");
    // HDB3: valid 000V and B00V, stray V after V, 4th zero flagged
    decDirected(2'd0, "P000PNP00PP0000", "100001000010000", "000000000010001", "R8,R9");
    // quiet line after reset not flagged until first pulse
    decDirected(2'd1, "00000P000", "000001000", "000000001", "R9");
    // reset from a busy state
    lineMode = 2'd0; codeEn = 1'b1;
    doReset();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule